// File: doc/BRIEF.md
# Phrase Table Playback Sequencer

This block turns a single spoken-message command into a chain of playback steps. A host presents a 5-bit message address. The sequencer then walks that address's slot in a phrase table, one item at a time. The table has up to eight items for each address, and it is held in an external synchronous ROM with one cycle of read latency.

Each item is one of two kinds:
- A reference to a stored phrase. The sequencer hands the phrase to a downstream phrase player with a one-cycle start pulse, together with the phrase's sample-rate code. It then generates the sample tick for that phrase until the player reports completion.
- A timed silence. The sequencer counts it internally in fixed silence units and flags that the analogue output should rest at mid-level. No sample data is used.

A command with address zero stops playback. A nonzero command issued at any time abandons the current list and starts the new one.

Top module: `phrase_seq`

## Requirements
- R1: While reset is held, and after it is released, the block is idle. `busy`, `playStart`, `playStop`, `sampleTick` and `silenceOn` are low, and `tblAddr` is zero.
- R2: A command with a nonzero address, sampled in cycle c, presents `tblAddr = {address, 3'b000}` in cycle c+1. The item read back then takes effect in cycle c+3: a phrase's start pulse, or the first cycle of a silence.
- R3: A table item is 11 bits. Bits 4:0 hold the phrase number or the silence count. Bit 7 set means silence. Bits 10:8 are the rate code. Bits 6:5 are reserved. An item with bits 4:0 equal to zero, or with either reserved bit set, ends the list: the block is idle one cycle after it is decoded.
- R4: A phrase item raises `playStart` for exactly one cycle, with `playPhrase` and `playRate` taken from the item. The sequencer holds until `playDone`. In the cycle after `playDone` it presents the next item index on `tblAddr`.
- R5: Rate codes 0 to 6 give sample periods of 16, 12, 10, 8, 6, 5 and 4 times `DIV_UNIT` clocks. Code 7 gives the same period as code 6. `sampleTick` is a single-cycle pulse that first appears one full period after the `playStart` cycle and then repeats once per period.
- R6: A silence item of count n keeps `silenceOn` high for exactly n × `UNIT_CLKS` cycles, with no start pulse during that time. The next item is fetched in the cycle after `silenceOn` falls.
- R7: After the eighth item of a list completes, the block returns to idle without reading further.
- R8: A command with address 0 makes the block idle in the next cycle. If a phrase was playing, `playStop` pulses for one cycle. When the block is already idle, a stop command has no effect on any output.
- R9: A nonzero command that arrives while a phrase is playing pulses `playStop` and restarts at item 0 of the new address, following the timing of R2.
- R10: A command that arrives in the same cycle as `playDone` takes priority over advancing to the next item.
- R11: `sampleTick` stays low outside phrase playback, and in particular during silence and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdAddr | input | ADDR_W | Message address; zero means stop |
| tblAddr | output | ADDR_W+IDX_W | Phrase table read address {message, item index} |
| tblData | input | 11 | Table item, valid one cycle after tblAddr |
| playStart | output | 1 | Start request to the phrase player |
| playPhrase | output | 5 | Phrase number for the player |
| playRate | output | 3 | Sample-rate code for the player |
| playDone | input | 1 | Player reports the phrase is finished |
| playStop | output | 1 | Abort pulse to the player |
| sampleTick | output | 1 | One pulse per sample period during a phrase |
| silenceOn | output | 1 | Output held at mid-level for a silence item |
| busy | output | 1 | A list is in progress |

## Verification
The hardest case to reach from the ports is a new command landing in exactly the cycle the player reports completion, because the advance path and the restart path then compete. The bench drives `playDone` and `cmdValid` at the same falling edge while a phrase plays. It then checks that the next table read is item 0 of the new address rather than item 1 of the old one. A run through all eight items of one address, and tick-spacing measurements taken at every rate code, cover the list-length limit and the divider map.

// File: rtl/phrase_seq_pkg.sv
package phrase_seq_pkg;

  localparam int FIELD_W    = 5;
  localparam int RATE_W     = 3;
  localparam int ITEM_W     = 11;
  localparam int MAX_FACTOR = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_PLAY,
    ST_SIL
  } seqState_t;

  typedef struct packed {
    logic newCmd;
    logic advance;
    logic loadPhrase;
    logic loadSilence;
    logic tickEn;
    logic silRun;
  } seqStrobe_t;

  // Sample period in multiples of the divider unit for each rate code.
  function automatic int unsigned rateFactor(input logic [RATE_W-1:0] code);
    case (code)
      3'd0:    return 16;
      3'd1:    return 12;
      3'd2:    return 10;
      3'd3:    return 8;
      3'd4:    return 6;
      3'd5:    return 5;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/phrase_seq_ctrl.sv
module phrase_seq_ctrl
  import phrase_seq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [FIELD_W-1:0] itemNum,
  input  logic               itemSil,
  input  logic [1:0]         itemRsvd,
  input  logic               playDone,
  input  logic               silDone,
  input  logic               idxLast,
  output seqStrobe_t         strb,
  output logic               playStart,
  output logic               playStop,
  output logic               busy,
  output logic               silenceOn
);

  seqState_t state, nextState;
  logic      startR, stopR;
  logic      itemEnd;

  assign itemEnd = (itemNum == '0) || (itemRsvd != 2'b00);

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        nextState = ST_IDLE;
      end
      ST_FETCH: begin
        nextState = ST_DECODE;
      end
      ST_DECODE: begin
        if (itemEnd) begin
          nextState = ST_IDLE;
        end else if (itemSil) begin
          strb.loadSilence = 1'b1;
          nextState        = ST_SIL;
        end else begin
          strb.loadPhrase = 1'b1;
          nextState       = ST_PLAY;
        end
      end
      ST_PLAY: begin
        strb.tickEn = 1'b1;
        if (playDone) begin
          if (idxLast) begin
            nextState = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            nextState    = ST_FETCH;
          end
        end
      end
      ST_SIL: begin
        strb.silRun = 1'b1;
        if (silDone) begin
          if (idxLast) begin
            nextState = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            nextState    = ST_FETCH;
          end
        end
      end
      default: begin
        nextState = ST_IDLE;
      end
    endcase
    // Commands override whatever the list walk wanted this cycle.
    if (cmdValid) begin
      strb.loadPhrase  = 1'b0;
      strb.loadSilence = 1'b0;
      strb.advance     = 1'b0;
      if (cmdAddr == '0) begin
        nextState = ST_IDLE;
      end else begin
        strb.newCmd = 1'b1;
        nextState   = ST_FETCH;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      startR <= 1'b0;
      stopR  <= 1'b0;
    end else begin
      state  <= nextState;
      startR <= strb.loadPhrase;
      stopR  <= cmdValid && (state == ST_PLAY);
    end
  end

  assign playStart = startR;
  assign playStop  = stopR;
  assign busy      = (state != ST_IDLE);
  assign silenceOn = (state == ST_SIL);

  // R4: a start request lasts one cycle only
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    playStart |=> !playStart);

  // R8: a stop command leaves the block idle
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAddr == '0) |=> !busy);

  // R9: an abort is only sent to a player that was running
  assert_abort_running_R9: assert property (@(posedge clk) disable iff (!rstN)
    playStop |-> $past(state == ST_PLAY));

  // R6: no phrase is started while silence is being timed
  assert_quiet_silence_R6: assert property (@(posedge clk) disable iff (!rstN)
    silenceOn |-> !playStart);

endmodule

// File: rtl/phrase_seq_dp.sv
module phrase_seq_dp
  import phrase_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MAX_ITEMS = 8,
  parameter int UNIT_CLKS = 131072,
  parameter int DIV_UNIT  = 64,
  localparam int IDX_W    = $clog2(MAX_ITEMS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strb,
  input  logic [ADDR_W-1:0]       cmdAddr,
  input  logic [FIELD_W-1:0]      itemNum,
  input  logic [RATE_W-1:0]       itemRate,
  output logic [ADDR_W+IDX_W-1:0] tblAddr,
  output logic [FIELD_W-1:0]      playPhrase,
  output logic [RATE_W-1:0]       playRate,
  output logic                    sampleTick,
  output logic                    silDone,
  output logic                    idxLast
);

  localparam int TICK_W = $clog2(MAX_FACTOR * DIV_UNIT + 1);
  localparam int SIL_W  = $clog2(UNIT_CLKS + 1);

  logic [ADDR_W-1:0]  xAddr;
  logic [IDX_W-1:0]   idx;
  logic [FIELD_W-1:0] phraseR;
  logic [RATE_W-1:0]  rateR;
  logic [TICK_W-1:0]  tickCnt;
  logic               tickR;
  logic [SIL_W-1:0]   silCnt;
  logic [FIELD_W-1:0] unitsLeft;

  function automatic logic [TICK_W-1:0] periodLast(input logic [RATE_W-1:0] code);
    return TICK_W'(rateFactor(code) * DIV_UNIT - 1);
  endfunction

  // list position: message address and item index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xAddr <= '0;
      idx   <= '0;
    end else if (strb.newCmd) begin
      xAddr <= cmdAddr;
      idx   <= '0;
    end else if (strb.advance) begin
      idx <= idx + 1'b1;
    end
  end

  assign tblAddr = {xAddr, idx};
  assign idxLast = (idx == IDX_W'(MAX_ITEMS - 1));

  // phrase parameters and sample tick divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phraseR <= '0;
      rateR   <= '0;
      tickCnt <= '0;
      tickR   <= 1'b0;
    end else begin
      if (strb.loadPhrase) begin
        phraseR <= itemNum;
        rateR   <= itemRate;
        tickCnt <= periodLast(itemRate);
      end else if (strb.tickEn) begin
        if (tickCnt == '0) tickCnt <= periodLast(rateR);
        else               tickCnt <= tickCnt - 1'b1;
      end
      tickR <= strb.tickEn && (tickCnt == '0);
    end
  end

  assign playPhrase = phraseR;
  assign playRate   = rateR;
  assign sampleTick = tickR && strb.tickEn;

  // silence timer: clocks within a unit, then units remaining
  always_ff @(posedge clk) begin
    if (!rstN) begin
      silCnt    <= '0;
      unitsLeft <= '0;
    end else if (strb.loadSilence) begin
      silCnt    <= SIL_W'(UNIT_CLKS - 1);
      unitsLeft <= itemNum;
    end else if (strb.silRun) begin
      if (silCnt == '0) begin
        silCnt    <= SIL_W'(UNIT_CLKS - 1);
        unitsLeft <= unitsLeft - 1'b1;
      end else begin
        silCnt <= silCnt - 1'b1;
      end
    end
  end

  assign silDone = strb.silRun && (silCnt == '0) && (unitsLeft == FIELD_W'(1));

  // R2: every new command restarts at item 0
  assert_restart_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.newCmd |=> (tblAddr[IDX_W-1:0] == '0));

  // R5: a sample tick is a single-cycle pulse
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> !sampleTick);

  // R11: no sample tick while silence is being timed
  assert_no_tick_silence_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.silRun |-> !sampleTick);

  // R6: the silence timer never runs with zero units left
  assert_sil_units_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.silRun |-> (unitsLeft != '0));

endmodule

// File: rtl/phrase_seq.sv
module phrase_seq
  import phrase_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MAX_ITEMS = 8,
  parameter int UNIT_CLKS = 131072,
  parameter int DIV_UNIT  = 64,
  localparam int IDX_W    = $clog2(MAX_ITEMS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [ADDR_W-1:0]       cmdAddr,
  output logic [ADDR_W+IDX_W-1:0] tblAddr,
  input  logic [ITEM_W-1:0]       tblData,
  output logic                    playStart,
  output logic [FIELD_W-1:0]      playPhrase,
  output logic [RATE_W-1:0]       playRate,
  input  logic                    playDone,
  output logic                    playStop,
  output logic                    sampleTick,
  output logic                    silenceOn,
  output logic                    busy
);

  seqStrobe_t         strb;
  logic               silDone;
  logic               idxLast;
  logic [FIELD_W-1:0] itemNum;
  logic               itemSil;
  logic [1:0]         itemRsvd;
  logic [RATE_W-1:0]  itemRate;

  assign itemNum  = tblData[FIELD_W-1:0];
  assign itemRsvd = tblData[6:5];
  assign itemSil  = tblData[7];
  assign itemRate = tblData[ITEM_W-1:8];

  phrase_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdAddr  (cmdAddr),
    .itemNum  (itemNum),
    .itemSil  (itemSil),
    .itemRsvd (itemRsvd),
    .playDone (playDone),
    .silDone  (silDone),
    .idxLast  (idxLast),
    .strb     (strb),
    .playStart(playStart),
    .playStop (playStop),
    .busy     (busy),
    .silenceOn(silenceOn)
  );

  phrase_seq_dp #(
    .ADDR_W   (ADDR_W),
    .MAX_ITEMS(MAX_ITEMS),
    .UNIT_CLKS(UNIT_CLKS),
    .DIV_UNIT (DIV_UNIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdAddr   (cmdAddr),
    .itemNum   (itemNum),
    .itemRate  (itemRate),
    .tblAddr   (tblAddr),
    .playPhrase(playPhrase),
    .playRate  (playRate),
    .sampleTick(sampleTick),
    .silDone   (silDone),
    .idxLast   (idxLast)
  );

endmodule

// File: tb/phrase_seq_bench.sv
module phrase_seq_bench;

  localparam int UNIT = 20;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [4:0]  cmdAddr;
  logic [7:0]  tblAddr;
  logic [10:0] tblData;
  logic        playStart;
  logic [4:0]  playPhrase;
  logic [2:0]  playRate;
  logic        playDone;
  logic        playStop;
  logic        sampleTick;
  logic        silenceOn;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  phrase_seq #(.UNIT_CLKS(UNIT), .DIV_UNIT(1)) u_phrase_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .tblAddr(tblAddr), .tblData(tblData), .playStart(playStart),
    .playPhrase(playPhrase), .playRate(playRate), .playDone(playDone),
    .playStop(playStop), .sampleTick(sampleTick), .silenceOn(silenceOn),
    .busy(busy)
  );

  logic [10:0] rom [0:255];
  always_ff @(posedge clk) tblData <= rom[tblAddr];

  function automatic logic [10:0] mk(input bit sil, input bit rsvd,
                                     input int rate, input int num);
    return {rate[2:0], sil, rsvd, 1'b0, num[4:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [4:0] a);
    cmdValid = 1'b1;
    cmdAddr  = a;
    step();
    cmdValid = 1'b0;
  endtask

  task automatic expectStart(input int num, input int rate, input string req);
    check(playStart == 1'b1, req, "playStart", int'(playStart), 1);
    check(playPhrase == 5'(num), req, "playPhrase", int'(playPhrase), num);
    check(playRate == 3'(rate), req, "playRate", int'(playRate), rate);
  endtask

  task automatic measureTicks(input int period, input int n, input string req);
    int bad = 0;
    for (int j = 1; j <= period * n; j++) begin
      step();
      if (sampleTick !== ((j % period) == 0)) bad++;
      if (playStart !== 1'b0) bad++;
    end
    check(bad == 0, req, "tick spacing mismatches", bad, 0);
  endtask

  task automatic finishPhrase();
    playDone = 1'b1;
    step();
    playDone = 1'b0;
  endtask

  task automatic countSilence(input int expCycles);
    int n = 0;
    int bad = 0;
    while (silenceOn === 1'b1 && n < 2000) begin
      n++;
      if (playStart || sampleTick) bad++;
      step();
    end
    check(n == expCycles, "R6", "silence cycles", n, expCycles);
    check(bad == 0, "R11", "start or tick during silence", bad, 0);
  endtask

  task automatic testReset();
    check(busy == 0 && playStart == 0 && playStop == 0, "R1", "control outputs",
          int'({busy, playStart, playStop}), 0);
    check(sampleTick == 0 && silenceOn == 0, "R1", "tick and silence",
          int'({sampleTick, silenceOn}), 0);
    check(tblAddr == 8'h00, "R1", "tblAddr", int'(tblAddr), 0);
  endtask

  task automatic testMixedList();
    sendCmd(5'd1);
    check(tblAddr == {5'd1, 3'd0}, "R2", "first fetch address", int'(tblAddr), 8);
    step(); step();
    expectStart(3, 3, "R2");
    measureTicks(8, 3, "R5");
    finishPhrase();
    check(tblAddr == {5'd1, 3'd1}, "R4", "next item address", int'(tblAddr), 9);
    step(); step();
    countSilence(2 * UNIT);
    check(tblAddr == {5'd1, 3'd2}, "R6", "fetch after silence", int'(tblAddr), 10);
    step(); step();
    expectStart(5, 6, "R4");
    measureTicks(4, 2, "R5");
    finishPhrase();
    step(); step();
    check(busy == 0, "R3", "busy after end item", int'(busy), 0);
  endtask

  task automatic testFullList();
    for (int k = 0; k < 8; k++) begin
      if (k == 0) sendCmd(5'd2);
      check(tblAddr == {5'd2, 3'(k)}, "R7", "item address", int'(tblAddr), 16 + k);
      step(); step();
      expectStart(k + 1, 0, "R4");
      repeat (3) step();
      finishPhrase();
    end
    check(busy == 0, "R7", "idle after eighth item", int'(busy), 0);
    step();
    check(playStart == 0, "R7", "no further start", int'(playStart), 0);
  endtask

  task automatic testStop();
    sendCmd(5'd3);
    step(); step();
    expectStart(9, 1, "R2");
    repeat (5) step();
    sendCmd(5'd0);
    check(busy == 0, "R8", "busy after stop", int'(busy), 0);
    check(playStop == 1, "R8", "playStop pulse", int'(playStop), 1);
    check(sampleTick == 0, "R11", "tick when idle", int'(sampleTick), 0);
    step();
    check(playStop == 0, "R8", "playStop width", int'(playStop), 0);
    sendCmd(5'd0);
    check(playStop == 0 && busy == 0, "R8", "stop while idle",
          int'({playStop, busy}), 0);
  endtask

  task automatic testReaddress();
    sendCmd(5'd3);
    step(); step();
    expectStart(9, 1, "R9");
    repeat (4) step();
    sendCmd(5'd1);
    check(playStop == 1, "R9", "abort pulse", int'(playStop), 1);
    check(tblAddr == {5'd1, 3'd0}, "R9", "restart address", int'(tblAddr), 8);
    step(); step();
    expectStart(3, 3, "R9");
    sendCmd(5'd0);
  endtask

  task automatic testPriorityAndRates();
    int nums[5]  = '{4, 6, 7, 8, 9};
    int rates[5] = '{5, 0, 4, 2, 1};
    int pers[5]  = '{5, 16, 6, 10, 12};
    sendCmd(5'd3);
    step(); step();
    expectStart(9, 1, "R10");
    step();
    playDone = 1'b1;
    sendCmd(5'd5);
    playDone = 1'b0;
    check(tblAddr == {5'd5, 3'd0}, "R10", "command beats done", int'(tblAddr), 40);
    step(); step();
    expectStart(2, 7, "R10");
    measureTicks(4, 2, "R5");
    for (int k = 0; k < 5; k++) begin
      finishPhrase();
      step(); step();
      expectStart(nums[k], rates[k], "R5");
      measureTicks(pers[k], 2, "R5");
    end
    finishPhrase();
    step(); step();
    check(busy == 0, "R3", "zero item ends list", int'(busy), 0);
  endtask

  task automatic testEndItems();
    sendCmd(5'd4);
    step(); step();
    check(busy == 0 && playStart == 0, "R3", "empty list",
          int'({busy, playStart}), 0);
    sendCmd(5'd6);
    step(); step();
    countSilence(UNIT);
    step(); step();
    check(busy == 0 && playStart == 0, "R3", "reserved bit ends list",
          int'({busy, playStart}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = '0;
    rom[{5'd1, 3'd0}] = mk(0, 0, 3, 3);
    rom[{5'd1, 3'd1}] = mk(1, 0, 0, 2);
    rom[{5'd1, 3'd2}] = mk(0, 0, 6, 5);
    for (int k = 0; k < 8; k++) rom[{5'd2, 3'(k)}] = mk(0, 0, 0, k + 1);
    rom[{5'd3, 3'd0}] = mk(0, 0, 1, 9);
    rom[{5'd3, 3'd1}] = mk(0, 0, 2, 10);
    rom[{5'd5, 3'd0}] = mk(0, 0, 7, 2);
    rom[{5'd5, 3'd1}] = mk(0, 0, 5, 4);
    rom[{5'd5, 3'd2}] = mk(0, 0, 0, 6);
    rom[{5'd5, 3'd3}] = mk(0, 0, 4, 7);
    rom[{5'd5, 3'd4}] = mk(0, 0, 2, 8);
    rom[{5'd5, 3'd5}] = mk(0, 0, 1, 9);
    rom[{5'd6, 3'd0}] = mk(1, 0, 0, 1);
    rom[{5'd6, 3'd1}] = mk(0, 1, 0, 3);

    rstN     = 1'b0;
    cmdValid = 1'b0;
    cmdAddr  = '0;
    playDone = 1'b0;
    repeat (3) step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();

    testMixedList();
    testFullList();
    testStop();
    testReaddress();
    testPriorityAndRates();
    testEndItems();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule